// File: doc/BRIEF.md
# Jitter-Absorbing Elastic Line Buffer

This block is a dual-pointer elastic store for a two-rail line signal. Every entry carries one positive-rail bit and one negative-rail bit. A falling edge of the jittered recovered line clock writes the current rail pair into the store. A rising edge of the smoothed local clock reads the oldest entry onto the output rails. Because the store sits half full in steady state, short-term phase wander between the two clocks is absorbed and does not reach the output. A limit flag warns when the fill level comes close to either end of the store.

The usable depth is 128 entries or 32 entries, chosen at run time. The store centres itself after power-up reset. It centres again on a filtered falling edge of the recentre pin, on any change of the depth select, and on leaving bypass. In bypass the line clock and both rails go straight to the outputs. Both line-side clocks are modelled as levels sampled by one fast system clock, and their edges are found inside the block.

The controller has three states. ST_CENTER is a one-cycle state that realigns the pointers. ST_RUN is normal operation. ST_BYPASS is the pass-through mode, in which the store is frozen. The transitions are:
- reset enters ST_CENTER.
- ST_CENTER goes to ST_RUN, or to ST_BYPASS if bypass is requested.
- ST_RUN goes to ST_BYPASS when bypass is requested. Otherwise it goes to ST_CENTER on a recentre edge or on a depth change.
- ST_BYPASS goes to ST_CENTER when bypass is released.

Top module: `elastic_line_buf`

## Requirements
- R1: Rail pairs written on successive falling edges of `line_clk_i` appear on `out_pos_o`/`out_neg_o` in the same order, one entry per rising edge of `smooth_clk_i`. The output changes two system clocks after the rising edge is sampled and holds between reads.
- R2: `short_sel_i` low selects a depth of 128 and high selects 32; the value is taken each time the store is centred. After centring, the fill level is half the depth (64 or 16). The first half-depth reads therefore return the entries that precede the write pointer.
- R3: `limit_o` is high while the fill level is at most the margin or at least depth minus the margin. The margin is 4 at depth 128 and 2 at depth 32. Otherwise `limit_o` is low.
- R4: After power-up reset the store is centred. The pre-written entries read back as 0 on both rails, and `limit_o` is low.
- R5: When `recentre_n_i` is high and then low for at least two system clocks, the store is recentred: the read pointer is placed half the depth behind the write pointer. A static level on the pin, a rising edge, or a low pulse of one system clock has no effect.
- R6: A change of `short_sel_i` during operation forces a recentre at the new depth.
- R7: While `bypass_i` is high, `out_clk_o`, `out_pos_o` and `out_neg_o` follow `line_clk_i`, `line_pos_i` and `line_neg_i` combinationally. In this mode `limit_o` is low, the store is frozen, and leaving bypass recentres the store.
- R8: A write that arrives while the store is full, with no read in the same cycle, is discarded. A read while the store is empty leaves the output rails unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all line-side signals |
| rst_n | input | 1 | Active-low power-up reset |
| line_clk_i | input | 1 | Jittered line clock level; a falling edge writes one entry |
| line_pos_i | input | 1 | Positive-rail data |
| line_neg_i | input | 1 | Negative-rail data |
| smooth_clk_i | input | 1 | Smoothed local clock level; a rising edge reads one entry |
| short_sel_i | input | 1 | Depth select: 0 = 128 entries, 1 = 32 entries |
| recentre_n_i | input | 1 | Recentre request, acting on a filtered falling edge |
| bypass_i | input | 1 | High passes the line clock and rails straight to the outputs |
| out_clk_o | output | 1 | Output clock: the smoothed clock, or the line clock in bypass |
| out_pos_o | output | 1 | Positive-rail output |
| out_neg_o | output | 1 | Negative-rail output |
| limit_o | output | 1 | Fill level near either end of the store |

## Verification
The assertions assume that every input is synchronous to `clk`. They also assume that each level of the line clock and of the smoothed clock lasts at least two system clocks, so that no two edges of one clock merge, and that the rails are stable at the sampled falling edge. The stimulus changes inputs only on the falling edge of `clk`. It holds each clock level for three system clocks and sets the rails together with the falling line-clock edge. After any recentre, depth change or bypass exit, it leaves idle cycles before the next edge, so that no edge lands in the single ST_CENTER cycle.

// File: rtl/elb_pkg.sv
package elb_pkg;

    typedef enum logic [1:0] {
        ST_CENTER = 2'd0,
        ST_RUN    = 2'd1,
        ST_BYPASS = 2'd2
    } elb_state_e;

    typedef struct packed {
        logic pos;
        logic neg;
    } elb_entry_t;

endpackage

// File: rtl/elb_edge_det.sv
module elb_edge_det #(
    parameter int STAGES = 2,
    parameter bit RISING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic edge_o
);
    localparam logic IDLE = ~RISING;

    logic [STAGES-1:0] tap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap_q <= {STAGES{IDLE}};
        end else begin
            tap_q <= {tap_q[STAGES-2:0], lvl_i};
        end
    end

    generate
        if (RISING) begin : g_rise
            assign edge_o = ~tap_q[STAGES-1] & (&tap_q[STAGES-2:0]);
        end else begin : g_fall
            assign edge_o = tap_q[STAGES-1] & ~(|tap_q[STAGES-2:0]);
        end
    endgenerate

    // R5
    edge_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);

endmodule

// File: rtl/elb_store.sv
module elb_store
    import elb_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  elb_entry_t    wr_data_i,
    input  logic          rd_en_i,
    input  logic [AW-1:0] rd_addr_i,
    output elb_entry_t    rd_data_o
);
    elb_entry_t mem [DEPTH];
    elb_entry_t rd_q;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cell
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem[g] <= '0;
                end else if (wr_en_i && (wr_addr_i == AW'(g))) begin
                    mem[g] <= wr_data_i;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en_i) begin
            rd_q <= mem[rd_addr_i];
        end
    end

    assign rd_data_o = rd_q;

endmodule

// File: rtl/elb_ctrl.sv
module elb_ctrl
    import elb_pkg::*;
#(
    parameter int DEPTH_LONG   = 128,
    parameter int DEPTH_SHORT  = 32,
    parameter int MARGIN_LONG  = 4,
    parameter int MARGIN_SHORT = 2,
    parameter int AW           = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ev_i,
    input  logic          rd_ev_i,
    input  logic          recentre_ev_i,
    input  logic          short_sel_i,
    input  logic          bypass_i,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic          rd_en_o,
    output logic [AW-1:0] rd_addr_o,
    output logic          limit_o
);
    localparam int FW = AW + 1;
    localparam logic [FW-1:0] D_L = FW'(DEPTH_LONG);
    localparam logic [FW-1:0] D_S = FW'(DEPTH_SHORT);
    localparam logic [FW-1:0] M_L = FW'(MARGIN_LONG);
    localparam logic [FW-1:0] M_S = FW'(MARGIN_SHORT);

    elb_state_e    state_q, state_d;
    logic          short_q;
    logic [AW-1:0] wr_ptr_q, rd_ptr_q;
    logic [FW-1:0] fill_q;

    logic [FW-1:0] depth_cur, depth_new, half_new, margin_cur;
    logic [AW-1:0] mask_cur, mask_new;
    logic          wr_ok, rd_ok, limit_run;

    always_comb begin
        depth_cur  = short_q ? D_S : D_L;
        depth_new  = short_sel_i ? D_S : D_L;
        half_new   = depth_new >> 1;
        margin_cur = short_q ? M_S : M_L;
        mask_cur   = AW'(depth_cur - FW'(1));
        mask_new   = AW'(depth_new - FW'(1));
        rd_ok      = rd_ev_i && (fill_q != '0);
        wr_ok      = wr_ev_i && ((fill_q != depth_cur) || rd_ok);
        limit_run  = (fill_q <= margin_cur) || (fill_q >= (depth_cur - margin_cur));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CENTER;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CENTER: state_d = bypass_i ? ST_BYPASS : ST_RUN;
            ST_RUN: begin
                if (bypass_i) begin
                    state_d = ST_BYPASS;
                end else if (recentre_ev_i || (short_sel_i != short_q)) begin
                    state_d = ST_CENTER;
                end
            end
            ST_BYPASS: begin
                if (!bypass_i) begin
                    state_d = ST_CENTER;
                end
            end
            default: state_d = ST_CENTER;
        endcase
    end

    // pointers and fill
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            short_q  <= 1'b0;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            fill_q   <= '0;
        end else begin
            unique case (state_q)
                ST_CENTER: begin
                    short_q  <= short_sel_i;
                    wr_ptr_q <= wr_ptr_q & mask_new;
                    rd_ptr_q <= (wr_ptr_q - half_new[AW-1:0]) & mask_new;
                    fill_q   <= half_new;
                end
                ST_RUN: begin
                    if (wr_ok) begin
                        wr_ptr_q <= (wr_ptr_q + AW'(1)) & mask_cur;
                    end
                    if (rd_ok) begin
                        rd_ptr_q <= (rd_ptr_q + AW'(1)) & mask_cur;
                    end
                    if (wr_ok && !rd_ok) begin
                        fill_q <= fill_q + FW'(1);
                    end else if (rd_ok && !wr_ok) begin
                        fill_q <= fill_q - FW'(1);
                    end
                end
                ST_BYPASS: begin
                end
                default: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        wr_en_o   = 1'b0;
        rd_en_o   = 1'b0;
        limit_o   = 1'b0;
        wr_addr_o = wr_ptr_q;
        rd_addr_o = rd_ptr_q;
        unique case (state_q)
            ST_RUN: begin
                wr_en_o = wr_ok;
                rd_en_o = rd_ok;
                limit_o = limit_run;
            end
            ST_CENTER, ST_BYPASS: begin
            end
            default: begin
            end
        endcase
    end

    // R2
    ptr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (((wr_ptr_q - rd_ptr_q) & mask_cur) == (fill_q[AW-1:0] & mask_cur)));

    // R8
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= depth_cur);

    // R8
    no_write_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && !rd_en_o) |-> (fill_q < depth_cur));

    // R8
    no_read_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> (fill_q != '0));

    // R5
    recentre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && recentre_ev_i && !bypass_i) |=> (state_q == ST_CENTER));

    // R7
    bypass_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BYPASS) |=> $stable(wr_ptr_q) && $stable(rd_ptr_q));

endmodule

// File: rtl/elastic_line_buf.sv
module elastic_line_buf
    import elb_pkg::*;
#(
    parameter int DEPTH_LONG   = 128,
    parameter int DEPTH_SHORT  = 32,
    parameter int MARGIN_LONG  = 4,
    parameter int MARGIN_SHORT = 2,
    parameter int PIN_STAGES   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_clk_i,
    input  logic line_pos_i,
    input  logic line_neg_i,
    input  logic smooth_clk_i,
    input  logic short_sel_i,
    input  logic recentre_n_i,
    input  logic bypass_i,
    output logic out_clk_o,
    output logic out_pos_o,
    output logic out_neg_o,
    output logic limit_o
);
    localparam int AW = $clog2(DEPTH_LONG);

    logic          wr_ev, rd_ev, recentre_ev;
    logic          wr_en, rd_en, limit_int;
    logic [AW-1:0] wr_addr, rd_addr;
    elb_entry_t    data_q, rd_data;

    // rails sampled alongside the first clock tap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            data_q <= '{pos: line_pos_i, neg: line_neg_i};
        end
    end

    elb_edge_det #(.STAGES(2), .RISING(1'b0)) u_wr_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(line_clk_i), .edge_o(wr_ev)
    );

    elb_edge_det #(.STAGES(2), .RISING(1'b1)) u_rd_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(smooth_clk_i), .edge_o(rd_ev)
    );

    elb_edge_det #(.STAGES(PIN_STAGES), .RISING(1'b0)) u_pin_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(recentre_n_i), .edge_o(recentre_ev)
    );

    elb_ctrl #(
        .DEPTH_LONG(DEPTH_LONG), .DEPTH_SHORT(DEPTH_SHORT),
        .MARGIN_LONG(MARGIN_LONG), .MARGIN_SHORT(MARGIN_SHORT), .AW(AW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_ev_i(wr_ev), .rd_ev_i(rd_ev), .recentre_ev_i(recentre_ev),
        .short_sel_i(short_sel_i), .bypass_i(bypass_i),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr),
        .rd_en_o(rd_en), .rd_addr_o(rd_addr),
        .limit_o(limit_int)
    );

    elb_store #(.DEPTH(DEPTH_LONG), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(data_q),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
    );

    always_comb begin
        if (bypass_i) begin
            out_clk_o = line_clk_i;
            out_pos_o = line_pos_i;
            out_neg_o = line_neg_i;
            limit_o   = 1'b0;
        end else begin
            out_clk_o = smooth_clk_i;
            out_pos_o = rd_data.pos;
            out_neg_o = rd_data.neg;
            limit_o   = limit_int;
        end
    end

    // R1
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R7
    bypass_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bypass_i) && bypass_i |-> !wr_en && !rd_en);

endmodule

// File: tb/elastic_line_buf_tb_top.sv
`timescale 1ns/1ps
module elastic_line_buf_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_clk = 1'b1, line_pos = 1'b0, line_neg = 1'b0;
    logic smooth_clk = 1'b0, short_sel = 1'b0, pin = 1'b1, bypass = 1'b0;
    logic out_clk, out_pos, out_neg, limit;

    int n_checks = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    elastic_line_buf dut_i (
        .clk(clk), .rst_n(rst_n),
        .line_clk_i(line_clk), .line_pos_i(line_pos), .line_neg_i(line_neg),
        .smooth_clk_i(smooth_clk), .short_sel_i(short_sel),
        .recentre_n_i(pin), .bypass_i(bypass),
        .out_clk_o(out_clk), .out_pos_o(out_pos), .out_neg_o(out_neg),
        .limit_o(limit)
    );

    function automatic logic pp(input int i);
        return ((i * 5 + 1) % 3) == 0;
    endfunction

    function automatic logic pn(input int i);
        return i[1] ^ i[3];
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic short_mode);
        @(negedge clk);
        rst_n = 1'b0; line_clk = 1'b1; smooth_clk = 1'b0; pin = 1'b1;
        bypass = 1'b0; short_sel = short_mode; line_pos = 1'b0; line_neg = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(4);
    endtask

    task automatic line_bit(input logic p, input logic n);
        line_pos = p; line_neg = n; line_clk = 1'b0;
        wait_cyc(3);
        line_clk = 1'b1;
        wait_cyc(3);
    endtask

    task automatic read_bit();
        smooth_clk = 1'b1;
        wait_cyc(3);
        smooth_clk = 1'b0;
        wait_cyc(3);
    endtask

    task automatic reads(input int n);
        for (int k = 0; k < n; k++) read_bit();
    endtask

    task automatic read_window(input string tag, input int n_low);
        reads(n_low);
        chk(tag, limit, 1'b0);
        read_bit();
        chk(tag, limit, 1'b1);
    endtask

    task automatic t_reset_state();
        do_reset(1'b0);
        chk("R4 pos after reset", out_pos, 1'b0);
        chk("R4 neg after reset", out_neg, 1'b0);
        chk("R4 limit after reset", limit, 1'b0);
        chk("R1 out clock follows smooth", out_clk, 1'b0);
    endtask

    task automatic t_order();
        do_reset(1'b0);
        for (int i = 0; i < 40; i++) line_bit(pp(i), pn(i));
        for (int j = 0; j < 64; j++) begin
            read_bit();
            chk("R4 centred prefill pos", out_pos, 1'b0);
            chk("R4 centred prefill neg", out_neg, 1'b0);
        end
        for (int j = 0; j < 40; j++) begin
            read_bit();
            chk("R1 order pos", out_pos, pp(j));
            chk("R1 order neg", out_neg, pn(j));
        end
        chk("R3 limit at empty", limit, 1'b1);
        read_bit();
        chk("R8 underflow holds pos", out_pos, pp(39));
        chk("R8 underflow holds neg", out_neg, pn(39));
    endtask

    task automatic t_limit_long();
        do_reset(1'b0);
        read_window("R3 long low margin", 59);
        do_reset(1'b0);
        for (int i = 0; i < 59; i++) line_bit(1'b0, 1'b1);
        chk("R3 long high margin below", limit, 1'b0);
        line_bit(1'b0, 1'b1);
        chk("R3 long high margin reached", limit, 1'b1);
        read_bit();
        chk("R3 long returns low", limit, 1'b0);
    endtask

    task automatic t_limit_short();
        do_reset(1'b1);
        for (int i = 0; i < 13; i++) line_bit(1'b1, 1'b0);
        chk("R3 short high margin below", limit, 1'b0);
        line_bit(1'b1, 1'b0);
        chk("R3 short high margin reached", limit, 1'b1);
    endtask

    task automatic t_overflow();
        do_reset(1'b0);
        for (int i = 0; i < 64; i++) line_bit(1'b0, 1'b0);
        chk("R3 limit at full", limit, 1'b1);
        line_bit(1'b1, 1'b1);
        read_bit();
        chk("R8 overflow write dropped pos", out_pos, 1'b0);
        chk("R8 overflow write dropped neg", out_neg, 1'b0);
    endtask

    task automatic t_recentre();
        do_reset(1'b0);
        reads(40);
        for (int i = 0; i < 80; i++) line_bit(pp(i), pn(i));
        pin = 1'b0;
        wait_cyc(8);
        for (int j = 0; j < 10; j++) begin
            read_bit();
            chk("R5 recentre data pos", out_pos, pp(16 + j));
            chk("R5 recentre data neg", out_neg, pn(16 + j));
        end
        wait_cyc(10);
        pin = 1'b1;
        wait_cyc(8);
        read_window("R5 static and rising pin ignored", 49);
    endtask

    task automatic t_glitch();
        do_reset(1'b0);
        reads(10);
        pin = 1'b0;
        wait_cyc(1);
        pin = 1'b1;
        wait_cyc(8);
        read_window("R5 glitch ignored", 49);
    endtask

    task automatic t_short();
        do_reset(1'b1);
        for (int i = 0; i < 5; i++) line_bit(pp(i), pn(i));
        for (int j = 0; j < 16; j++) begin
            read_bit();
            chk("R2 short prefill pos", out_pos, 1'b0);
        end
        for (int j = 0; j < 5; j++) begin
            read_bit();
            chk("R2 short order pos", out_pos, pp(j));
            chk("R2 short order neg", out_neg, pn(j));
        end
        short_sel = 1'b0;
        wait_cyc(5);
        read_window("R6 change to long recentres", 59);
        short_sel = 1'b1;
        wait_cyc(5);
        read_window("R6 change to short recentres", 13);
    endtask

    task automatic t_bypass();
        do_reset(1'b0);
        reads(60);
        chk("R3 limit before bypass", limit, 1'b1);
        bypass = 1'b1;
        #1;
        chk("R7 limit low in bypass", limit, 1'b0);
        wait_cyc(2);
        for (int k = 0; k < 4; k++) begin
            line_pos = k[0]; line_neg = k[1]; line_clk = k[0] ^ k[1];
            smooth_clk = ~k[0];
            #1;
            chk("R7 bypass pos", out_pos, k[0]);
            chk("R7 bypass neg", out_neg, k[1]);
            chk("R7 bypass clock", out_clk, k[0] ^ k[1]);
            wait_cyc(3);
        end
        line_clk = 1'b1; smooth_clk = 1'b0;
        wait_cyc(3);
        bypass = 1'b0;
        wait_cyc(5);
        read_window("R7 bypass exit recentres", 59);
    endtask

    initial begin
        t_reset_state();
        t_order();
        t_limit_long();
        t_limit_short();
        t_overflow();
        t_recentre();
        t_glitch();
        t_short();
        t_bypass();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        #3000000;
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule